// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the scan timing for a parallel RGB panel. Software programs the active width and height, the front porch, sync pulse and back porch of each axis, and a pixel-rate divider through a small register port. Once the run bit is set, a horizontal and a vertical counter walk the frame and drive active-high horizontal sync, vertical sync and active-video outputs, plus the pixel column and row during active video.

Every timing field holds its count minus one, so a field of zero means one pixel or one line. Each line runs through its active pixels first, then the front porch, the sync pulse and the back porch. Each frame runs through its lines in the same order.

A frame interrupt sets a sticky pending bit. Its source is either the first cycle of vertical sync or the start of a programmable line. Software clears the bit by writing a one to it. A soft-reset command sends both counters back to the first pixel and drops the pending bit.

Top module: `raster_timer`

## Requirements
- R1: After reset, hsyncOut, vsyncOut, activeVideo, pixX, pixY and irq are 0, and every register reads 0.
- R2: Register 1 holds active width minus one in bits [CW-1:0]. Register 2 holds back porch minus one in [7:0], front porch minus one in [15:8] and sync width minus one in [23:16], all counted in pixels. Within a line, the column runs through active, front porch, sync and back porch, and hsyncOut is high only during the sync columns.
- R3: Registers 3 and 4 hold the same fields for lines. vsyncOut is high for every pixel of the sync lines, and the rows follow the same order as the columns.
- R4: activeVideo is high only when both column and row are in their active regions. While it is high, pixX and pixY give the column and row. While it is low, both are 0.
- R5: Register 5 bits [7:0] hold the divider minus one. Each pixel position lasts divider-field plus one clock cycles.
- R6: Register 0 bit 0 is the run bit. While it is 0, the counters stay at the first pixel and hsyncOut, vsyncOut, activeVideo, pixX and pixY are all 0. Once it is set, scanning starts at column 0, row 0 in the next cycle.
- R7: When register 0 bit 2 (interrupt enable) is 1 and bit 3 (source) is 0, the pending bit and irq go high one cycle after the first cycle of vsyncOut.
- R8: When register 0 bit 3 is 1, the pending bit goes high one cycle after the first cycle of column 0 on the row held in register 6 bits [CW-1:0].
- R9: Writing register 7 with bit 0 set clears the pending bit. Writing register 7 with bit 0 clear leaves it unchanged.
- R10: When a source event and a clearing write to register 7 fall in the same cycle, the pending bit ends up set.
- R11: Writing register 0 with bit 1 set returns both counters to column 0, row 0 and clears the pending bit. Bit 1 is not stored.
- R12: Registers 0 to 6 read back their stored fields. Register 7 reads the pending bit in bit 0.
- R13: With interrupt enable 0, the pending bit is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 3*PW | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 3*PW | Register read data (combinational) |
| hsyncOut | output | 1 | Horizontal sync, active high |
| vsyncOut | output | 1 | Vertical sync, active high |
| activeVideo | output | 1 | High inside the active area |
| pixX | output | CW | Column during active video |
| pixY | output | CW | Row during active video |
| irq | output | 1 | Frame interrupt pending |

## Verification
The vertical-sync event that sets the pending bit and a software write that clears it can fall in the same cycle. The bench provokes this by counting cycles from the start of scanning and placing the clearing write exactly on the first cycle in which vsyncOut is seen high. Setting must win, so irq has to read high in the following cycle. A later clearing write placed away from any event must bring irq low, and a write of zero must leave it high.

// File: rtl/rt_pkg.sv
package rt_pkg;

  typedef enum logic [2:0] {
    ADR_CTRL  = 3'd0,
    ADR_HACT  = 3'd1,
    ADR_HPOR  = 3'd2,
    ADR_VACT  = 3'd3,
    ADR_VPOR  = 3'd4,
    ADR_DIV   = 3'd5,
    ADR_THR   = 3'd6,
    ADR_STAT  = 3'd7
  } rtAddr_t;

  typedef struct packed {
    logic run;
    logic pixStep;
    logic clear;
  } rtStrobe_t;

endpackage

// File: rtl/rt_ctrl.sv
module rt_ctrl
  import rt_pkg::*;
#(
  parameter int CW   = 12,
  parameter int PW   = 8,
  parameter int DIVW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [3*PW-1:0]   wrData,
  input  logic [2:0]        rdAddr,
  output logic [3*PW-1:0]   rdData,
  input  logic              vsyncIn,
  input  logic              lineHitIn,
  output rtStrobe_t         strb,
  output logic [CW-1:0]     hAct,
  output logic [PW-1:0]     hFp,
  output logic [PW-1:0]     hSync,
  output logic [PW-1:0]     hBp,
  output logic [CW-1:0]     vAct,
  output logic [PW-1:0]     vFp,
  output logic [PW-1:0]     vSync,
  output logic [PW-1:0]     vBp,
  output logic [CW-1:0]     thresh,
  output logic              irq
);
  localparam int DW = 3 * PW;

  logic            runQ, irqEnQ, irqSrcQ, pendingQ;
  logic [DIVW-1:0] divQ, divCnt;
  logic            vsyncQ, lineHitQ;
  logic            wrCtrl, softRst, w1c, evt, evtQual;

  assign wrCtrl  = wrEn && (rtAddr_t'(wrAddr) == ADR_CTRL);
  assign softRst = wrCtrl && wrData[1];
  assign w1c     = wrEn && (rtAddr_t'(wrAddr) == ADR_STAT) && wrData[0];
  assign evt     = irqSrcQ ? (lineHitIn && !lineHitQ) : (vsyncIn && !vsyncQ);
  assign evtQual = irqEnQ && evt;

  assign strb.run     = runQ;
  assign strb.clear   = softRst || !runQ;
  assign strb.pixStep = runQ && (divCnt == divQ);
  assign irq          = pendingQ;

  // Register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ <= 1'b0; irqEnQ <= 1'b0; irqSrcQ <= 1'b0;
      hAct <= '0; hFp <= '0; hSync <= '0; hBp <= '0;
      vAct <= '0; vFp <= '0; vSync <= '0; vBp <= '0;
      divQ <= '0; thresh <= '0;
    end else if (wrEn) begin
      case (rtAddr_t'(wrAddr))
        ADR_CTRL: begin
          runQ    <= wrData[0];
          irqEnQ  <= wrData[2];
          irqSrcQ <= wrData[3];
        end
        ADR_HACT: hAct <= wrData[CW-1:0];
        ADR_HPOR: begin
          hBp   <= wrData[PW-1:0];
          hFp   <= wrData[2*PW-1:PW];
          hSync <= wrData[3*PW-1:2*PW];
        end
        ADR_VACT: vAct <= wrData[CW-1:0];
        ADR_VPOR: begin
          vBp   <= wrData[PW-1:0];
          vFp   <= wrData[2*PW-1:PW];
          vSync <= wrData[3*PW-1:2*PW];
        end
        ADR_DIV:  divQ   <= wrData[DIVW-1:0];
        ADR_THR:  thresh <= wrData[CW-1:0];
        default: ;
      endcase
    end
  end

  // Divider, edge detectors and pending bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      vsyncQ   <= 1'b0;
      lineHitQ <= 1'b0;
      pendingQ <= 1'b0;
    end else begin
      if (strb.clear || strb.pixStep) divCnt <= '0;
      else                            divCnt <= divCnt + 1'b1;
      vsyncQ   <= strb.clear ? 1'b0 : vsyncIn;
      lineHitQ <= strb.clear ? 1'b0 : lineHitIn;
      if (softRst)      pendingQ <= 1'b0;
      else if (evtQual) pendingQ <= 1'b1;
      else if (w1c)     pendingQ <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    case (rtAddr_t'(rdAddr))
      ADR_CTRL: rdData = DW'({irqSrcQ, irqEnQ, 1'b0, runQ});
      ADR_HACT: rdData = DW'(hAct);
      ADR_HPOR: rdData = {hSync, hFp, hBp};
      ADR_VACT: rdData = DW'(vAct);
      ADR_VPOR: rdData = {vSync, vFp, vBp};
      ADR_DIV:  rdData = DW'(divQ);
      ADR_THR:  rdData = DW'(thresh);
      ADR_STAT: rdData = DW'(pendingQ);
      default:  rdData = '0;
    endcase
  end

  assert_pend_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (evtQual && !softRst) |=> pendingQ);

  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rstN)
    (w1c && !evtQual) |=> !pendingQ);

  assert_soft_clr_R11: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> !pendingQ);

  assert_div_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.pixStep |=> (divCnt == '0));

endmodule

// File: rtl/rt_datapath.sv
module rt_datapath
  import rt_pkg::*;
#(
  parameter int CW = 12,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  rtStrobe_t     strb,
  input  logic [CW-1:0] hAct,
  input  logic [PW-1:0] hFp,
  input  logic [PW-1:0] hSync,
  input  logic [PW-1:0] hBp,
  input  logic [CW-1:0] vAct,
  input  logic [PW-1:0] vFp,
  input  logic [PW-1:0] vSync,
  input  logic [PW-1:0] vBp,
  input  logic [CW-1:0] thresh,
  output logic          hsyncOut,
  output logic          vsyncOut,
  output logic          activeOut,
  output logic [CW-1:0] pixX,
  output logic [CW-1:0] pixY,
  output logic          lineHit
);
  localparam int CNTW = CW + 2;

  logic [CNTW-1:0] hCnt, vCnt;
  logic [CNTW-1:0] hSyncStart, hSyncEnd, hLast;
  logic [CNTW-1:0] vSyncStart, vSyncEnd, vLast;

  // Region boundaries; every field is stored as count minus one
  always_comb begin
    hSyncStart = CNTW'(hAct) + CNTW'(hFp) + CNTW'(2);
    hSyncEnd   = hSyncStart + CNTW'(hSync) + CNTW'(1);
    hLast      = hSyncEnd + CNTW'(hBp);
    vSyncStart = CNTW'(vAct) + CNTW'(vFp) + CNTW'(2);
    vSyncEnd   = vSyncStart + CNTW'(vSync) + CNTW'(1);
    vLast      = vSyncEnd + CNTW'(vBp);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (strb.clear) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (strb.pixStep) begin
      if (hCnt >= hLast) begin
        hCnt <= '0;
        vCnt <= (vCnt >= vLast) ? '0 : vCnt + 1'b1;
      end else begin
        hCnt <= hCnt + 1'b1;
      end
    end
  end

  always_comb begin
    hsyncOut  = strb.run && (hCnt >= hSyncStart) && (hCnt < hSyncEnd);
    vsyncOut  = strb.run && (vCnt >= vSyncStart) && (vCnt < vSyncEnd);
    activeOut = strb.run && (hCnt <= CNTW'(hAct)) && (vCnt <= CNTW'(vAct));
    pixX      = activeOut ? hCnt[CW-1:0] : '0;
    pixY      = activeOut ? vCnt[CW-1:0] : '0;
    lineHit   = strb.run && (hCnt == '0) && (vCnt == CNTW'(thresh));
  end

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (hCnt == '0) && (vCnt == '0));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.pixStep && !strb.clear) |=> ($stable(hCnt) && $stable(vCnt)));

  assert_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    activeOut |-> !(hsyncOut || vsyncOut));

endmodule

// File: rtl/raster_timer.sv
module raster_timer
  import rt_pkg::*;
#(
  parameter int CW   = 12,
  parameter int PW   = 8,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [2:0]      wrAddr,
  input  logic [3*PW-1:0] wrData,
  input  logic [2:0]      rdAddr,
  output logic [3*PW-1:0] rdData,
  output logic            hsyncOut,
  output logic            vsyncOut,
  output logic            activeVideo,
  output logic [CW-1:0]   pixX,
  output logic [CW-1:0]   pixY,
  output logic            irq
);
  rtStrobe_t     strb;
  logic [CW-1:0] hAct, vAct, thresh;
  logic [PW-1:0] hFp, hSync, hBp, vFp, vSync, vBp;
  logic          lineHit;

  rt_ctrl #(.CW(CW), .PW(PW), .DIVW(DIVW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .vsyncIn(vsyncOut), .lineHitIn(lineHit),
    .strb(strb), .hAct(hAct), .hFp(hFp), .hSync(hSync), .hBp(hBp),
    .vAct(vAct), .vFp(vFp), .vSync(vSync), .vBp(vBp), .thresh(thresh),
    .irq(irq)
  );

  rt_datapath #(.CW(CW), .PW(PW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hAct(hAct), .hFp(hFp), .hSync(hSync), .hBp(hBp),
    .vAct(vAct), .vFp(vFp), .vSync(vSync), .vBp(vBp), .thresh(thresh),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .activeOut(activeVideo),
    .pixX(pixX), .pixY(pixY), .lineHit(lineHit)
  );

endmodule

// File: tb/raster_timer_tb.sv
module raster_timer_tb;
  localparam int CW = 12;
  localparam int PW = 8;
  // Small frame: widths in pixels/lines
  localparam int HA = 4, HF = 2, HS = 3, HB = 1;
  localparam int VA = 3, VF = 1, VS = 2, VB = 2;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            wrEn = 1'b0;
  logic [2:0]      wrAddr = '0;
  logic [3*PW-1:0] wrData = '0;
  logic [2:0]      rdAddr = '0;
  logic [3*PW-1:0] rdData;
  logic            hsyncOut, vsyncOut, activeVideo, irq;
  logic [CW-1:0]   pixX, pixY;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  raster_timer #(.CW(CW), .PW(PW), .DIVW(8)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut),
    .activeVideo(activeVideo), .pixX(pixX), .pixY(pixY), .irq(irq)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      nChecks = nChecks + 1;
      nFails  = nFails + 1;
      $display("FAIL watchdog: act=%0d exp=<100000 cycles", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks = nChecks + 1;
    if (!ok) begin
      nFails = nFails + 1;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic chkEq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  // Called at a negedge; write edge is the next posedge; returns at the next negedge
  task automatic wr(input int addr, input int data);
    wrEn = 1'b1; wrAddr = 3'(addr); wrData = (3*PW)'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chkIdle(input string tag);
    chkEq({tag, " hsync"}, int'(hsyncOut), 0);
    chkEq({tag, " vsync"}, int'(vsyncOut), 0);
    chkEq({tag, " active"}, int'(activeVideo), 0);
    chkEq({tag, " pixX"}, int'(pixX), 0);
    chkEq({tag, " pixY"}, int'(pixY), 0);
  endtask

  // Sweep cycles from scan start (cycle 0), divider field d, model outputs and pending
  task automatic sweep(input int d, input int n, input bit irqOn, input string irqTag);
    bit prevVs = 1'b0, prev2 = 1'b0, exPend = 1'b0;
    for (int c = 0; c < n; c++) begin
      int pos = c / (d + 1);
      int h = pos % HT;
      int v = (pos / HT) % VT;
      bit eA = (h < HA) && (v < VA);
      bit eH = (h >= HA + HF) && (h < HA + HF + HS);
      bit eV = (v >= VA + VF) && (v < VA + VF + VS);
      string dtag = (d == 0) ? "" : " R5";
      if (irqOn && prevVs && !prev2) exPend = 1'b1;
      chkEq({"R2 hsync", dtag}, int'(hsyncOut), int'(eH));
      chkEq({"R3 vsync", dtag}, int'(vsyncOut), int'(eV));
      chkEq({"R4 active", dtag}, int'(activeVideo), int'(eA));
      chkEq({"R4 pixX", dtag}, int'(pixX), eA ? h : 0);
      chkEq({"R4 pixY", dtag}, int'(pixY), eA ? v : 0);
      chkEq(irqTag, int'(irq), int'(exPend));
      prev2 = prevVs;
      prevVs = eV;
      @(negedge clk);
    end
  endtask

  initial begin
    steps(3);
    // R1 reset state
    chkIdle("R1");
    chkEq("R1 irq", int'(irq), 0);
    for (int a = 0; a < 8; a++) begin
      rdAddr = 3'(a);
      #0;
      chkEq("R1 reg read", int'(rdData), 0);
    end
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkIdle("R1 after release");

    // Program the small frame
    wr(1, HA - 1);
    wr(2, ((HS - 1) << 16) | ((HF - 1) << 8) | (HB - 1));
    wr(3, VA - 1);
    wr(4, ((VS - 1) << 16) | ((VF - 1) << 8) | (VB - 1));
    wr(5, 0);
    wr(6, 1);
    // R12 readback
    rdAddr = 3'd2; #1 chkEq("R12 hporch read", int'(rdData), 32'h020100);
    rdAddr = 3'd4; #1 chkEq("R12 vporch read", int'(rdData), 32'h010001);
    rdAddr = 3'd1; #1 chkEq("R12 hact read", int'(rdData), HA - 1);
    rdAddr = 3'd6; #1 chkEq("R12 thresh read", int'(rdData), 1);
    // R6 not running
    steps(2);
    chkIdle("R6 stopped");

    // Main sweep: divider 1, vsync interrupt on
    wr(0, 32'h7);
    rdAddr = 3'd0; #1 chkEq("R12 ctrl read (soft bit not stored) R11", int'(rdData), 5);
    sweep(0, 2 * HT * VT, 1'b1, "R7 irq");

    // R6 stop then idle
    wr(0, 0);
    for (int i = 0; i < 4; i++) begin
      chkIdle("R6 after stop");
      @(negedge clk);
    end

    // R5 divider 3 cycles per pixel, interrupt off (R13)
    wr(5, 2);
    wr(0, 32'h3);
    sweep(2, HT * VT, 1'b0, "R13 irq");
    wr(0, 0);
    wr(5, 0);

    // R10 set vs clear collision at the vsync rise (cycle 40)
    wr(0, 32'h7);
    steps((VA + VF) * HT);
    chkEq("R10 vsync first cycle", int'(vsyncOut), 1);
    chkEq("R10 irq before event", int'(irq), 0);
    wr(7, 1);                       // clear lands on the event cycle
    chkEq("R10 set wins over clear", int'(irq), 1);
    steps(4);
    wr(7, 0);
    chkEq("R9 write zero keeps pending", int'(irq), 1);
    rdAddr = 3'd7; #1 chkEq("R12 status read", int'(rdData), 1);
    @(negedge clk);

    // R11 soft reset while running with pending set
    wr(0, 32'h7);
    chkEq("R11 irq cleared", int'(irq), 0);
    chkEq("R11 active at origin", int'(activeVideo), 1);
    chkEq("R11 pixX origin", int'(pixX), 0);
    chkEq("R11 pixY origin", int'(pixY), 0);
    steps((VA + VF) * HT + 1);
    chkEq("R7 pending after vsync", int'(irq), 1);
    steps(5);
    wr(7, 1);
    chkEq("R9 clear by write one", int'(irq), 0);
    rdAddr = 3'd7; #1 chkEq("R9 status read cleared", int'(rdData), 0);
    @(negedge clk);

    // R8 line threshold source, row 1
    wr(0, 0);
    wr(0, 32'hF);
    steps(HT);
    chkEq("R8 row 1 start pixY", int'(pixY), 1);
    chkEq("R8 irq not yet", int'(irq), 0);
    @(negedge clk);
    chkEq("R8 irq after row 1 start", int'(irq), 1);

    // R13 interrupt disabled over a full frame
    wr(0, 0);
    wr(0, 32'h3);
    steps(HT * VT + 10);
    chkEq("R13 irq stays low", int'(irq), 0);

    summary();
    $finish;
  end

endmodule